// File: doc/BRIEF.md
# Double-Buffered Colour Palette

This block is a 256-colour palette with two banks. The display pipeline looks up colours in one bank while the host fills the other. A pixel path takes an 8-bit colour index each cycle. One cycle later it returns the 24-bit RGB value stored at that index in the bank currently on screen.

The host reaches the block through addressed word writes and reads. It has a window of palette words and one control word. Each palette word holds one colour: red in bits 23:16, green in 15:8 and blue in 7:0. Through the control word, software asks for a bank exchange by flipping a request bit. The exchange happens only at the next frame-start pulse from the timing generator, so a frame never shows a mix of two palettes. A status bit follows the request bit once the exchange is done. While the two bits differ, software knows that a swap is still waiting.

The host always sees the bank that is off screen. Writes go to that bank, and palette reads return its contents. A whole new palette can therefore be built, checked and then presented in one step.

Top module: `clut_pingpong`

## Requirements
- R1: After reset the request bit and status bit are both 0, bank 0 is on screen, the pixel output is 0 and every entry of both banks holds 0.
- R2: Palette entry n is at host address 0x400 + 4·n (n = 0..255). A write stores data bits 23:0 as red 23:16, green 15:8, blue 7:0. Data bits 31:24 are dropped, and a read returns them as 0.
- R3: Host palette writes land only in the bank that is not on screen, so the pixel output never changes because of a host write.
- R4: A host read with the read strobe high returns its data on hostRdData one cycle later. A palette address returns the off-screen bank's entry. In any cycle that follows a cycle without a read strobe, hostRdData is 0.
- R5: The control word is at address 0x218. Bit 0 is the request bit, readable and writable. Bit 1 is the status bit, read-only; a write to bit 1 has no effect. All other bits read as 0.
- R6: On a frame-start pulse with the request bit differing from the status bit, the status bit takes the request value and the bank on screen flips.
- R7: A frame-start pulse while the request and status bits are equal changes neither the status bit nor the bank on screen.
- R8: pixRgb equals the on-screen bank's entry at the index presented in the previous cycle. The on-screen bank is the bank whose number equals the status bit.
- R9: The status bit never changes except on a frame-start pulse. A pending request stays visible as request ≠ status until that pulse.
- R10: Host writes to addresses outside the palette window and the control word change nothing, and reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read strobe |
| hostAddr | input | 12 | Host byte address |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Host read data, one cycle after the read strobe |
| frameStart | input | 1 | One-cycle pulse at the start of each frame |
| pixIndex | input | 8 | Colour index from the display pipeline |
| pixRgb | output | 24 | Looked-up colour, one cycle after the index |

## Verification
Several properties are checked on every cycle:
- The status bit moves only on a frame-start pulse.
- A pending request is completed by the next pulse.
- A settled pulse leaves the status bit alone.
- A palette write never targets the bank on screen.
- The pixel output holds while the index and the on-screen bank stay put.
- The read data is 0 after an idle cycle.

Only the bench scenarios can show the rest: the data values themselves, the address-to-entry mapping and the dropped upper data bits. They also cover the fact that the host reads the opposite bank after a swap, and that writes to the read-only status bit or to unmapped addresses leave state untouched.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int unsigned IDX_W   = 8;
  localparam int unsigned RGB_W   = 24;
  localparam int unsigned ENTRIES = 1 << IDX_W;

  // Strobes and selects from the control side to the storage side
  typedef struct packed {
    logic             palWrite;
    logic [IDX_W-1:0] wrIndex;
    logic [RGB_W-1:0] wrRgb;
    logic [IDX_W-1:0] rdIndex;
    logic             hostBank;
    logic             dispBank;
  } clutCmd_t;
endpackage

// File: rtl/clut_ctrl.sv
module clut_ctrl
  import clut_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] PAL_BASE = 12'h400,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 12'h218
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              frameStart,
  input  logic [RGB_W-1:0]  hostRgb,
  output clutCmd_t          cmd
);
  localparam int unsigned WIN_LSB = IDX_W + 2;

  logic swReq;
  logic status;
  logic palHit;
  logic ctlHit;
  logic [DATA_W-1:0] rdNext;
  logic unusedHiBits;

  assign palHit = (hostAddr[ADDR_W-1:WIN_LSB] == PAL_BASE[ADDR_W-1:WIN_LSB]);
  assign ctlHit = (hostAddr == CTL_ADDR);
  assign unusedHiBits = ^hostWrData[DATA_W-1:RGB_W];

  // Request bit written by host, status follows only at frame start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      swReq  <= 1'b0;
      status <= 1'b0;
    end else begin
      if (hostWrEn && ctlHit) swReq <= hostWrData[0];
      if (frameStart && (swReq != status)) status <= swReq;
    end
  end

  always_comb begin
    rdNext = '0;
    if (hostRdEn) begin
      if (ctlHit)      rdNext = {{(DATA_W-2){1'b0}}, status, swReq};
      else if (palHit) rdNext = {{(DATA_W-RGB_W){1'b0}}, hostRgb};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) hostRdData <= '0;
    else       hostRdData <= rdNext;
  end

  always_comb begin
    cmd.palWrite = hostWrEn && palHit;
    cmd.wrIndex  = hostAddr[WIN_LSB-1:2];
    cmd.rdIndex  = hostAddr[WIN_LSB-1:2];
    cmd.wrRgb    = hostWrData[RGB_W-1:0];
    cmd.hostBank = ~status;
    cmd.dispBank = status;
  end

  // R9: status moves only on a frame pulse
  p_status_at_frame_r9: assert property (@(posedge clk) disable iff (!rstN)
    (status != $past(status)) |-> $past(frameStart));

  // R6: pending request completes at frame start
  p_swap_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && (swReq != status)) |=> (status == $past(swReq)));

  // R7: settled pulse leaves status alone
  p_no_swap_settled_r7: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && (swReq == status)) |=> $stable(status));

  // R4: idle cycle yields zero read data
  p_idle_read_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    !hostRdEn |=> (hostRdData == '0));
endmodule

// File: rtl/clut_store.sv
module clut_store
  import clut_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  clutCmd_t         cmd,
  input  logic [IDX_W-1:0] pixIndex,
  output logic [RGB_W-1:0] pixRgb,
  output logic [RGB_W-1:0] hostRgb
);
  logic [RGB_W-1:0] bankMem [2][ENTRIES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < 2; b++)
        for (int e = 0; e < int'(ENTRIES); e++)
          bankMem[b][e] <= '0;
      pixRgb <= '0;
    end else begin
      if (cmd.palWrite) bankMem[cmd.hostBank][cmd.wrIndex] <= cmd.wrRgb;
      pixRgb <= bankMem[cmd.dispBank][pixIndex];
    end
  end

  assign hostRgb = bankMem[cmd.hostBank][cmd.rdIndex];

  // R3: writes never target the on-screen bank
  p_write_offscreen_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.palWrite |-> (cmd.hostBank != cmd.dispBank));

  // R8: steady index and bank give a steady colour
  p_pix_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((pixIndex == $past(pixIndex)) && (cmd.dispBank == $past(cmd.dispBank)))
      |=> $stable(pixRgb));
endmodule

// File: rtl/clut_pingpong.sv
module clut_pingpong
  import clut_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] PAL_BASE = 12'h400,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 12'h218
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              frameStart,
  input  logic [IDX_W-1:0]  pixIndex,
  output logic [RGB_W-1:0]  pixRgb
);
  clutCmd_t         cmd;
  logic [RGB_W-1:0] hostRgb;

  clut_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAL_BASE(PAL_BASE), .CTL_ADDR(CTL_ADDR)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .frameStart(frameStart), .hostRgb(hostRgb), .cmd(cmd)
  );

  clut_store uStore (
    .clk(clk), .rstN(rstN), .cmd(cmd), .pixIndex(pixIndex),
    .pixRgb(pixRgb), .hostRgb(hostRgb)
  );
endmodule

// File: tb/sim_clut_pingpong.sv
module sim_clut_pingpong;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic        hostRdEn = 1'b0;
  logic [11:0] hostAddr = '0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic        frameStart = 1'b0;
  logic [7:0]  pixIndex = '0;
  logic [23:0] pixRgb;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [23:0] model [2][256];
  logic reqM = 1'b0;
  logic statM = 1'b0;

  always #4 clk = ~clk;

  clut_pingpong u0 (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .frameStart(frameStart), .pixIndex(pixIndex), .pixRgb(pixRgb)
  );

  function automatic logic [31:0] expRead(input logic [11:0] a);
    if (a == 12'h218) return {30'd0, statM, reqM};
    if (a[11:10] == 2'b01) return {8'd0, model[~statM][a[9:2]]};
    return 32'd0;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [11:0] a, input logic [31:0] d);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
    if (a == 12'h218) reqM = d[0];
    else if (a[11:10] == 2'b01) model[~statM][a[9:2]] = d[23:0];
  endtask

  task automatic hostRead(input logic [11:0] a, input string tag);
    logic [31:0] e;
    e = expRead(a);
    hostRdEn = 1'b1; hostAddr = a;
    @(negedge clk);
    hostRdEn = 1'b0;
    check(hostRdData, e, tag);
  endtask

  task automatic pixCheck(input logic [7:0] i, input string tag);
    pixIndex = i;
    @(negedge clk);
    check({8'd0, pixRgb}, {8'd0, model[statM][i]}, tag);
  endtask

  task automatic framePulse;
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    if (reqM != statM) statM = reqM;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'd4242);
    for (int b = 0; b < 2; b++)
      for (int e = 0; e < 256; e++) model[b][e] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    hostRead(12'h218, "R1 ctrl reset");
    pixCheck(8'd17, "R1 pixel reset");
    hostRead(12'h400 + 12'd4 * 12'd200, "R1 palette reset");

    // R2 / R4 fill off-screen bank, read back
    for (int k = 0; k < 40; k++) begin
      logic [7:0] ix;
      ix = 8'($urandom % 256);
      hostWrite(12'h400 + {2'b00, ix, 2'b00}, $urandom);
      hostRead(12'h400 + {2'b00, ix, 2'b00}, "R2 R4 readback");
    end
    hostWrite(12'h400, 32'hFF123456);
    hostWrite(12'h7FC, 32'hA5ABCDEF);
    hostRead(12'h400, "R2 first entry upper bits dropped");
    hostRead(12'h7FC, "R2 last entry");
    // R4 idle cycle gives zero
    @(negedge clk);
    check(hostRdData, 32'd0, "R4 idle read zero");

    // R3 display unaffected by writes
    pixCheck(8'd0, "R3 display bank untouched");
    pixCheck(8'd255, "R3 display bank untouched last");

    // R5 request with read-only status bit ignored
    hostWrite(12'h218, 32'h0000_0003);
    hostRead(12'h218, "R5 R9 pending request");
    pixCheck(8'd0, "R9 no swap before frame");

    // R6 swap at frame start
    framePulse();
    hostRead(12'h218, "R6 status follows request");
    pixCheck(8'd0, "R6 new bank on screen");
    pixCheck(8'd255, "R8 new bank last entry");
    hostRead(12'h400, "R4 host sees old bank");

    // R7 settled frame pulse
    framePulse();
    hostRead(12'h218, "R7 settled pulse");
    pixCheck(8'd0, "R7 bank unchanged");

    // R10 unmapped address
    hostWrite(12'h100, 32'hFFFF_FFFF);
    hostWrite(12'h21C, 32'hFFFF_FFFF);
    hostRead(12'h100, "R10 unmapped read");
    hostRead(12'h218, "R10 ctrl unchanged");

    // Random mix
    for (int k = 0; k < 600; k++) begin
      int op;
      logic [7:0] ix;
      op = int'($urandom % 6);
      ix = 8'($urandom % 256);
      case (op)
        0: hostWrite(12'h400 + {2'b00, ix, 2'b00}, $urandom);
        1: hostRead(12'h400 + {2'b00, ix, 2'b00}, "R4 random read");
        2: pixCheck(ix, "R8 random pixel");
        3: hostWrite(12'h218, {$urandom} & 32'h3);
        4: framePulse();
        default: hostRead(12'h218, "R9 random ctrl");
      endcase
    end
    for (int e = 0; e < 256; e += 37) pixCheck(8'(e), "R8 sweep");

    done = 1;
    summary();
    $finish;
  end
endmodule